// File: doc/BRIEF.md
# Offset-Slipped Energy Integration Window Controller

This block sequences a single energy integrator so that each summing window lines up with the boundaries of a received bit. It runs on a fast clock that is eight times the bit-rate clock used by neighbouring logic. One pass through its sequence takes eight fast-clock cycles when no correction is needed. Each pass clears the accumulator for two cycles, then waits in a slip state. The integrator then adds one squared-and-digitised sample per cycle for four cycles, and a final cycle presents the sum with a one-cycle valid pulse.

An external estimator supplies an unsigned timing correction on `offsetIn`. The controller captures it once per pass, on the clock edge that enters the slip state. It then lengthens the slip state by that many cycles, so the integration window moves later by a whole number of fast-clock cycles. The next pass starts immediately after the valid cycle. Repeated corrections therefore walk the window across the bit period until the estimator reports zero.

Top module: `intWindowCtrl`

## Requirements
- R1: While the synchronous, active-high `rst` is sampled high on a rising edge, the controller returns to the first clear cycle. In the cycle after such an edge, `sumValid` is 0, `inWindow` is 0 and `sumOut` is 0.
- R2: Each pass begins with two clear cycles, which are pass cycles 0 and 1. `sumOut` reads 0 in pass cycles 1 and 2.
- R3: The 4-bit unsigned value on `offsetIn` is captured at the edge that ends pass cycle 1. With captured value N, the slip state spans pass cycles 2 through 2+N, which is 1+N cycles.
- R4: With a captured value of 0, the slip state lasts exactly one cycle and a whole pass lasts exactly 8 cycles.
- R5: Changes on `offsetIn` after the capture edge have no effect on the current pass.
- R6: `inWindow` is 1 in exactly four consecutive cycles, pass cycles 3+N to 6+N. The `sampleIn` value present in each of those cycles is added to a 6-bit unsigned accumulator without wrap. Four samples of 15 give 60.
- R7: `sumValid` is a single-cycle pulse in pass cycle 7+N. In that cycle `sumOut` equals the sum of the four window samples. The next cycle is pass cycle 0 of a new pass.
- R8: Outside the window and the clear cycles the accumulator holds. `sumOut` in pass cycle 0 still shows the previous pass's sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, eight times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| offsetIn | input | 4 | Unsigned slip amount in clock cycles from the offset estimator |
| sampleIn | input | 4 | Squared, digitised energy sample |
| sumOut | output | 6 | Accumulator value; the window sum while `sumValid` is high |
| sumValid | output | 1 | One-cycle pulse marking the presented sum |
| inWindow | output | 1 | High in the four cycles whose samples are summed |

## Verification
The assertions assume that `offsetIn` and `sampleIn` are sampled only at rising edges, and that any 4-bit value may appear on them in any cycle. They also assume that reset may arrive in any state. The bench drives its inputs only at falling edges, so each value is stable across the edge that uses it. It changes `offsetIn` both once per run and on every cycle, which places changes inside the slip state. It includes a run of all-maximum samples, the largest slip amount, and a reset in the middle of a pass.

// File: rtl/intwin_pkg.sv
package intwin_pkg;

  // number of cycles in the summing window
  localparam int WIN_N = 4;

  typedef enum logic [2:0] {
    ST_CLR0  = 3'd0,
    ST_CLR1  = 3'd1,
    ST_SLIP  = 3'd2,
    ST_ACC0  = 3'd3,
    ST_ACC1  = 3'd4,
    ST_ACC2  = 3'd5,
    ST_ACC3  = 3'd6,
    ST_HOLD  = 3'd7
  } winState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic add;
    logic done;
  } dpStrobe_t;

endpackage

// File: rtl/intwin_ctrl.sv
module intwin_ctrl
  import intwin_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] offsetIn,
  output dpStrobe_t        stb
);

  winState_t        state;
  winState_t        stateNext;
  logic [OFF_W-1:0] slipCnt;

  always_comb begin
    stateNext = state;
    case (state)
      ST_CLR0: stateNext = ST_CLR1;
      ST_CLR1: stateNext = ST_SLIP;
      ST_SLIP: stateNext = (slipCnt == '0) ? ST_ACC0 : ST_SLIP;
      ST_ACC0: stateNext = ST_ACC1;
      ST_ACC1: stateNext = ST_ACC2;
      ST_ACC2: stateNext = ST_ACC3;
      ST_ACC3: stateNext = ST_HOLD;
      ST_HOLD: stateNext = ST_CLR0;
      default: stateNext = ST_CLR0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_CLR0;
      slipCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_CLR1) begin
        slipCnt <= offsetIn;          // capture on entry to slip state
      end else if (state == ST_SLIP && slipCnt != '0) begin
        slipCnt <= slipCnt - 1'b1;
      end
    end
  end

  always_comb begin
    stb.clr  = (state == ST_CLR0) || (state == ST_CLR1);
    stb.add  = (state == ST_ACC0) || (state == ST_ACC1) ||
               (state == ST_ACC2) || (state == ST_ACC3);
    stb.done = (state == ST_HOLD);
  end

  AST_CLEAR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLR0) |=> (state == ST_CLR1)); // R2
  AST_SLIP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLR1) |=> (state == ST_SLIP) && (slipCnt == $past(offsetIn))); // R3
  AST_SLIP_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLIP && slipCnt != '0) |=>
      (state == ST_SLIP) && (slipCnt == $past(slipCnt) - 1'b1)); // R5
  AST_ZERO_SLIP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLIP && slipCnt == '0) |=> (state == ST_ACC0)); // R4
  AST_HOLD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> (state == ST_CLR0)); // R7

endmodule

// File: rtl/intwin_datapath.sv
module intwin_datapath
  import intwin_pkg::*;
#(
  parameter int SAMPLE_W = 4,
  parameter int ACC_W    = SAMPLE_W + $clog2(WIN_N)
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           stb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [ACC_W-1:0]    sumOut,
  output logic                sumValid,
  output logic                inWindow
);

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || stb.clr) begin
      acc <= '0;
    end else if (stb.add) begin
      acc <= acc + ACC_W'(sampleIn);
    end
  end

  assign sumOut   = acc;
  assign sumValid = stb.done;
  assign inWindow = stb.add;

  AST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    stb.clr |=> (acc == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    stb.add |=> (acc >= $past(acc))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stb.add && !stb.clr) |=> $stable(acc)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stb.done |=> !stb.done); // R7
  AST_SUM_PRESENTED: assert property (@(posedge clk) disable iff (rst)
    stb.done |=> $stable(sumOut)); // R8

endmodule

// File: rtl/intWindowCtrl.sv
module intWindowCtrl
  import intwin_pkg::*;
#(
  parameter int OFF_W    = 4,
  parameter int SAMPLE_W = 4,
  localparam int ACC_W   = SAMPLE_W + $clog2(WIN_N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OFF_W-1:0]    offsetIn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [ACC_W-1:0]    sumOut,
  output logic                sumValid,
  output logic                inWindow
);

  dpStrobe_t stb;

  intwin_ctrl #(
    .OFF_W (OFF_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .offsetIn (offsetIn),
    .stb      (stb)
  );

  intwin_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .sampleIn (sampleIn),
    .sumOut   (sumOut),
    .sumValid (sumValid),
    .inWindow (inWindow)
  );

endmodule

// File: tb/test_intWindowCtrl.sv
module test_intWindowCtrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] offsetIn = '0;
  logic [3:0] sampleIn = '0;
  logic [5:0] sumOut;
  logic       sumValid;
  logic       inWindow;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  // behavioural reference: position in pass, captured slip, running sum
  int mPos = 0;
  int mOff = 0;
  int mAcc = 0;

  always #5 clk = ~clk;

  intWindowCtrl i_intWindowCtrl (
    .clk      (clk),
    .rst      (rst),
    .offsetIn (offsetIn),
    .sampleIn (sampleIn),
    .sumOut   (sumOut),
    .sumValid (sumValid),
    .inWindow (inWindow)
  );

  always @(posedge clk) begin
    bit lastCycle;
    if (rst) begin
      mPos = 0; mOff = 0; mAcc = 0;
    end else begin
      if (mPos <= 1) mAcc = 0;
      else if (mPos >= 3 + mOff && mPos <= 6 + mOff) mAcc = mAcc + int'(sampleIn);
      lastCycle = (mPos == 7 + mOff);
      if (mPos == 1) mOff = int'(offsetIn);
      mPos = lastCycle ? 0 : mPos + 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit    expWin;
    string tWin, tSum, tVal;
    expWin = (mPos >= 3 + mOff) && (mPos <= 6 + mOff);
    if (rst) begin
      tWin = "R1"; tSum = "R1"; tVal = "R1";
    end else begin
      tVal = "R7";
      if (mPos >= 2 && int'(offsetIn) != mOff) tWin = "R5";
      else if (mOff == 0) tWin = "R4";
      else tWin = "R3";
      if (mPos == 1 || mPos == 2) tSum = "R2";
      else if (mPos == 0) tSum = "R8";
      else tSum = "R6";
    end
    chk(tWin, "inWindow", int'(inWindow), int'(expWin));
    chk(tVal, "sumValid", int'(sumValid), int'(mPos == 7 + mOff));
    chk(tSum, "sumOut", int'(sumOut), mAcc);
  endtask

  // mode: 0 fixed offset/random sample, 1 fixed offset/max sample, 2 random both each cycle
  task automatic runCycles(int n, int mode, int offVal);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      case (mode)
        0: begin offsetIn = 4'(offVal); sampleIn = 4'($urandom_range(0, 15)); end
        1: begin offsetIn = 4'(offVal); sampleIn = 4'd15; end
        default: begin
          offsetIn = 4'($urandom_range(0, 15));
          sampleIn = 4'($urandom_range(0, 15));
        end
      endcase
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  initial begin
    rst = 1'b1;
    runCycles(3, 0, 0);                 // R1 reset state
    rst = 1'b0;
    runCycles(40, 0, 0);                // R4 zero slip
    runCycles(24, 1, 0);                // R6 max samples, sum 60
    runCycles(60, 0, 15);               // R3 largest slip
    runCycles(400, 2, 0);               // R5 offset changes mid-pass
    runCycles(5, 0, 7);
    rst = 1'b1;                         // R1 reset mid-pass
    runCycles(2, 0, 7);
    rst = 1'b0;
    runCycles(200, 0, 5);               // R3 fixed slip
    for (int k = 0; k < 60; k++) runCycles(17, 0, $urandom_range(0, 15));
    runCycles(40, 1, 2);                // R6 max samples with slip
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule